// File: doc/BRIEF.md
# Dual-Bank Shared-Address Memory

This block models a storage array split into two banks, A and B, that share one set of low address lines, one write strobe, one output strobe and one data word. Each bank has its own active-low select and its own top address bit. A bank's full word address is its own top bit above the shared low bits. One write can therefore place the same word into both banks, each at its own address.

All control and data inputs are sampled on the rising clock edge. The bidirectional bus of a physical memory is split into an input word, an output word and a drive-enable flag that stands in for the tristate buffer. Read data, the drive flag, a conflict flag and a standby flag appear one clock after the cycle that caused them. The shared low address width is a parameter. It defaults to a small value so the block elaborates quickly, and it can be raised to 15 to give 65,536 words per bank.

Top module: `dual_bank_mem`

## Requirements
- R1: With `a_sel_n`=0 and `wr_n`=0, `wr_data` is stored in bank A at word address {`a_hi`, `lo_addr`}, with `a_hi` as the most significant bit.
- R2: With `b_sel_n`=0 and `wr_n`=0, `wr_data` is stored in bank B at word address {`b_hi`, `lo_addr`}.
- R3: With both selects at 0 and `wr_n`=0, the same word is stored in both banks in the same cycle. Each bank uses its own top bit.
- R4: With exactly one select at 0, `wr_n`=1 and `oe_n`=0, the next cycle has `rd_drive`=1 and `rd_data` equal to the stored word of the selected bank at its address.
- R5: During a write, `oe_n` is ignored: the next cycle has `rd_drive`=0 whatever the value of `oe_n`.
- R6: With one select at 0, `wr_n`=1 and `oe_n`=1, the next cycle has `rd_drive`=0, `standby`=0 and `conflict`=0.
- R7: With both selects at 1, the next cycle has `standby`=1 and `rd_drive`=0, and neither bank is written, whatever `wr_n` and `oe_n` are.
- R8: With both selects at 0, `wr_n`=1 and `oe_n`=0, the next cycle has `conflict`=1 and `rd_drive`=0.
- R9: `rd_data` is all zeros in every cycle in which `rd_drive` is 0.
- R10: A write to one bank leaves the other bank's word at the same address unchanged.
- R11: While `rst_n` is 0 at a clock edge, the outputs become `rd_drive`=0, `conflict`=0 and `standby`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_addr | input | LOW_AW | Shared low address bits |
| a_sel_n | input | 1 | Bank A select, active low |
| a_hi | input | 1 | Bank A top address bit |
| b_sel_n | input | 1 | Bank B select, active low |
| b_hi | input | 1 | Bank B top address bit |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| wr_data | input | DATA_W | Data to store |
| rd_data | output | DATA_W | Data read, zero when not driven |
| rd_drive | output | 1 | Bus drive enable |
| conflict | output | 1 | Read with both banks selected |
| standby | output | 1 | Neither bank selected |

## Verification
On every cycle, the assertions check how the sampled control pins map to the next cycle's flags: a read raises the drive enable, a write or an output disable keeps it low, standby and conflict raise their own flags, and at most one flag is set at a time. Only the bench's scenarios can show the data path. These scenarios cover the word that returns from each bank at an address made from its own top bit, a dual write landing in both banks, an ignored write in standby, and the other bank staying untouched. The bench also checks that the output word is zero whenever nothing is driven.

// File: rtl/dbm_pkg.sv
// Shared types for the dual-bank memory.
// Assumes: a single decoded operation per sampled cycle.
package dbm_pkg;
    typedef enum logic [2:0] {
        OP_STANDBY,
        OP_HOLD,
        OP_READ_A,
        OP_READ_B,
        OP_WRITE,
        OP_CONFLICT
    } dbm_op_e;
endpackage

// File: rtl/dbm_decode.sv
// Control decoder: turns the select, write and output strobes into one
// operation code plus a write enable per bank.
// Assumes: all strobes are active low and sampled by the caller's registers.
module dbm_decode
    import dbm_pkg::*;
(
    input  logic    a_sel_n,
    input  logic    b_sel_n,
    input  logic    wr_n,
    input  logic    oe_n,
    output dbm_op_e op,
    output logic    wr_a,
    output logic    wr_b
);
    // Priority: standby, then write, then output disable, then read kind.
    always_comb begin
        if (a_sel_n && b_sel_n)
            op = OP_STANDBY;
        else if (!wr_n)
            op = OP_WRITE;
        else if (oe_n)
            op = OP_HOLD;
        else if (!a_sel_n && !b_sel_n)
            op = OP_CONFLICT;
        else if (!a_sel_n)
            op = OP_READ_A;
        else
            op = OP_READ_B;
    end

    // Per-bank write strobes; both may be high for a dual write.
    always_comb begin
        wr_a = !a_sel_n && !wr_n;
        wr_b = !b_sel_n && !wr_n;
    end
endmodule

// File: rtl/dbm_bank.sv
// One storage bank with a synchronous write port and a registered read port.
// Assumes: the array contents are not reset; the read port is unused in a
// write cycle, so write/read ordering at one address does not matter.
module dbm_bank #(
    parameter int AW     = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word when this bank's write strobe is set.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // Capture the addressed word every cycle.
    always_ff @(posedge clk) begin
        rdata <= mem[addr];
    end
endmodule

// File: rtl/dbm_out.sv
// Output stage: registers the decoded operation's flags and picks which
// bank's word reaches the output, zeroing it when nothing is driven.
// Assumes: the bank read words are registered on the same edge as the flags.
module dbm_out
    import dbm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dbm_op_e           op,
    input  logic [DATA_W-1:0] q_a,
    input  logic [DATA_W-1:0] q_b,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    output logic              conflict,
    output logic              standby
);
    logic pick_b_q;

    // Register the flags for the operation sampled on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_drive <= 1'b0;
            conflict <= 1'b0;
            standby  <= 1'b1;
            pick_b_q <= 1'b0;
        end else begin
            rd_drive <= (op == OP_READ_A) || (op == OP_READ_B);
            conflict <= (op == OP_CONFLICT);
            standby  <= (op == OP_STANDBY);
            pick_b_q <= (op == OP_READ_B);
        end
    end

    // Route the chosen bank's word out, zero when the bus is released.
    always_comb begin
        if (!rd_drive)
            rd_data = '0;
        else if (pick_b_q)
            rd_data = q_b;
        else
            rd_data = q_a;
    end
endmodule

// File: rtl/dual_bank_mem.sv
// Dual-bank memory with shared low address, one write strobe, one output
// strobe and one data word; each bank has its own select and top address bit.
// Assumes: inputs are synchronous to clk; the tristate bus is modelled as
// wr_data in, rd_data out and rd_drive as the driver enable.
module dual_bank_mem
    import dbm_pkg::*;
#(
    parameter int LOW_AW = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOW_AW-1:0] lo_addr,
    input  logic              a_sel_n,
    input  logic              a_hi,
    input  logic              b_sel_n,
    input  logic              b_hi,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    output logic              conflict,
    output logic              standby
);
    localparam int BANK_AW = LOW_AW + 1;
    localparam int NBANKS  = 2;

    dbm_op_e           op;
    logic              wr_a, wr_b;
    logic [NBANKS-1:0] bank_we;
    logic [NBANKS-1:0] bank_hi;
    logic [DATA_W-1:0] bank_q [NBANKS];

    dbm_decode u_dec (
        .a_sel_n (a_sel_n),
        .b_sel_n (b_sel_n),
        .wr_n    (wr_n),
        .oe_n    (oe_n),
        .op      (op),
        .wr_a    (wr_a),
        .wr_b    (wr_b)
    );

    // Gather per-bank controls into vectors indexed by bank (0 = A, 1 = B).
    always_comb begin
        bank_we = {wr_b, wr_a};
        bank_hi = {b_hi, a_hi};
    end

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        dbm_bank #(.AW(BANK_AW), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .we    (bank_we[g]),
            .addr  ({bank_hi[g], lo_addr}),
            .wdata (wr_data),
            .rdata (bank_q[g])
        );
    end

    dbm_out #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .q_a      (bank_q[0]),
        .q_b      (bank_q[1]),
        .rd_data  (rd_data),
        .rd_drive (rd_drive),
        .conflict (conflict),
        .standby  (standby)
    );
endmodule

// File: rtl/dbm_checker.sv
// Protocol checker for dual_bank_mem: relates sampled control pins to the
// next cycle's output flags. Attached through bind.
module dbm_checker #(
    parameter int LOW_AW = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LOW_AW-1:0] lo_addr,
    input logic              a_sel_n,
    input logic              b_sel_n,
    input logic              wr_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_drive,
    input logic              conflict,
    input logic              standby
);
    logic one_sel;
    logic unused_ok;
    always_comb one_sel = a_sel_n ^ b_sel_n;
    always_comb unused_ok = ^{lo_addr, rd_data};

    assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (one_sel && wr_n && !oe_n) |=> (rd_drive && !conflict && !standby));

    assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(a_sel_n && b_sel_n) && !wr_n) |=> !rd_drive);

    assert_out_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (one_sel && wr_n && oe_n) |=> (!rd_drive && !standby && !conflict));

    assert_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sel_n && b_sel_n) |=> (standby && !rd_drive));

    assert_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_sel_n && !b_sel_n && wr_n && !oe_n) |=> (conflict && !rd_drive));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_drive, conflict, standby}));
endmodule

bind dual_bank_mem dbm_checker #(.LOW_AW(LOW_AW), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_addr  (lo_addr),
    .a_sel_n  (a_sel_n),
    .b_sel_n  (b_sel_n),
    .wr_n     (wr_n),
    .oe_n     (oe_n),
    .rd_data  (rd_data),
    .rd_drive (rd_drive),
    .conflict (conflict),
    .standby  (standby)
);

// File: tb/tb_dual_bank_mem.sv
module tb_dual_bank_mem;
    localparam int LOW_AW = 6;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LOW_AW-1:0] lo_addr = '0;
    logic              a_sel_n = 1'b1, a_hi = 1'b0;
    logic              b_sel_n = 1'b1, b_hi = 1'b0;
    logic              wr_n = 1'b1, oe_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_drive, conflict, standby;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dual_bank_mem #(.LOW_AW(LOW_AW), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .lo_addr(lo_addr),
        .a_sel_n(a_sel_n), .a_hi(a_hi), .b_sel_n(b_sel_n), .b_hi(b_hi),
        .wr_n(wr_n), .oe_n(oe_n), .wr_data(wr_data),
        .rd_data(rd_data), .rd_drive(rd_drive),
        .conflict(conflict), .standby(standby)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle at a negedge; returns at the next negedge with outputs updated.
    task automatic cyc(input logic an, input logic ah, input logic bn, input logic bh,
                       input int lo, input logic w, input logic o, input logic [15:0] d);
        a_sel_n = an; a_hi = ah; b_sel_n = bn; b_hi = bh;
        lo_addr = LOW_AW'(lo); wr_n = w; oe_n = o; wr_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_a(input logic ah, input int lo);
        cyc(1'b0, ah, 1'b1, 1'b0, lo, 1'b1, 1'b0, 16'h0);
    endtask

    task automatic rd_b(input logic bh, input int lo);
        cyc(1'b1, 1'b0, 1'b0, bh, lo, 1'b1, 1'b0, 16'h0);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 drive", {31'b0, rd_drive}, 32'd0);
        check("R11 conflict", {31'b0, conflict}, 32'd0);
        check("R11 standby", {31'b0, standby}, 32'd1);
        check("R9 reset data", {16'b0, rd_data}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_single_writes;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5, 1'b0, 1'b1, 16'h1234);
        check("R5 write no drive", {31'b0, rd_drive}, 32'd0);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 5, 1'b0, 1'b1, 16'hABCD);
        rd_a(1'b0, 5);
        check("R1 read A", {16'b0, rd_data}, 32'h1234);
        check("R4 drive A", {31'b0, rd_drive}, 32'd1);
        rd_b(1'b1, 5);
        check("R2 read B", {16'b0, rd_data}, 32'hABCD);
        check("R4 drive B", {31'b0, rd_drive}, 32'd1);
    endtask

    task automatic t_dual_write;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 3, 1'b0, 1'b1, 16'h7777);
        rd_a(1'b1, 3);
        check("R3 bank A copy", {16'b0, rd_data}, 32'h7777);
        rd_b(1'b0, 3);
        check("R3 bank B copy", {16'b0, rd_data}, 32'h7777);
    endtask

    task automatic t_isolation;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 9, 1'b0, 1'b1, 16'h5555);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 9, 1'b0, 1'b1, 16'hAAAA);
        rd_b(1'b0, 9);
        check("R10 B untouched", {16'b0, rd_data}, 32'h5555);
        rd_a(1'b0, 9);
        check("R10 A written", {16'b0, rd_data}, 32'hAAAA);
    endtask

    task automatic t_oe_ignored;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 7, 1'b0, 1'b0, 16'h0F0F);
        check("R5 oe low write drive", {31'b0, rd_drive}, 32'd0);
        check("R9 data zero in write", {16'b0, rd_data}, 32'd0);
        rd_a(1'b0, 7);
        check("R5 write took effect", {16'b0, rd_data}, 32'h0F0F);
    endtask

    task automatic t_out_disable;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5, 1'b1, 1'b1, 16'h0);
        check("R6 drive", {31'b0, rd_drive}, 32'd0);
        check("R6 standby", {31'b0, standby}, 32'd0);
        check("R6 conflict", {31'b0, conflict}, 32'd0);
        check("R9 data zero", {16'b0, rd_data}, 32'd0);
    endtask

    task automatic t_standby;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 5, 1'b0, 1'b0, 16'hFFFF);
        check("R7 standby", {31'b0, standby}, 32'd1);
        check("R7 drive", {31'b0, rd_drive}, 32'd0);
        rd_a(1'b0, 5);
        check("R7 A unwritten", {16'b0, rd_data}, 32'h1234);
        rd_b(1'b1, 5);
        check("R7 B unwritten", {16'b0, rd_data}, 32'hABCD);
    endtask

    task automatic t_conflict;
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 5, 1'b1, 1'b0, 16'h0);
        check("R8 conflict", {31'b0, conflict}, 32'd1);
        check("R8 drive", {31'b0, rd_drive}, 32'd0);
        check("R9 data zero conflict", {16'b0, rd_data}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single_writes();
        t_dual_write();
        t_isolation();
        t_oe_ignored();
        t_out_disable();
        t_standby();
        t_conflict();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule